// File: doc/BRIEF.md
# Prescaled Timebase Update Generator

This block is the time-base core of a general-purpose timer. It takes a count-enable tick, which already reflects whatever clock source was chosen elsewhere. The tick passes through three stages. A prescale divider comes first. A main counter follows, bounded by a reload limit. A repetition counter comes last. A single-cycle `update_o` pulse fires each time the repetition counter runs out. With the tick held high every cycle, an up- or down-counting configuration pulses once every (DIV+1)·(TOP+1)·(REPS+1) cycles.

The main counter can count up and wrap at the limit, or count down and reload the limit after zero. It can also run centre-aligned, counting up to the limit and back down, with a counter event at each turning point. Software can force an update by writing a trigger register, and an external slave controller can force one through an input pin. Either forced update restarts all three stages. The divider and the reload limit are double-buffered: a written value becomes active only at the next update.

Register writes use a single-cycle write port. The registers are:

| Address | Name | Meaning |
|---------|------|---------|
| 0 | CTRL | bit 0 = run enable; bit 1 = count down; bits [3:2] = centre field |
| 1 | DIV | prescale divider |
| 2 | TOP | reload limit |
| 3 | REPS | repetition count |
| 4 | TRIG | write 1 to bit 0 to force an update |

Top module: `timebase_gen`

## Requirements
- R1: With the tick high every cycle in an edge-aligned mode, the cycles between consecutive update pulses equal (DIV+1)·(TOP+1)·(REPS+1). For example, DIV=1, TOP=65535, REPS=0 gives 131072 cycles, which is about 549.3 Hz from a 72 MHz tick.
- R2: With CTRL bit 1 = 0 and CTRL[3:2] = 0, the counter steps 0,1,…,TOP and then wraps to 0. The wrap is a counter event.
- R3: With CTRL bit 1 = 1 and CTRL[3:2] = 0, the counter steps TOP,…,0 and then reloads TOP. The reload is a counter event.
- R4: With CTRL[3:2] nonzero, the counter runs 0 up to TOP and back down to 0. Reaching TOP is a counter event, and reaching 0 is a counter event. For TOP ≥ 1, updates are spaced (DIV+1)·TOP·(REPS+1) cycles apart.
- R5: Writing 1 to TRIG bit 0 makes `update_o` high in the next cycle. It also clears the divider and sets the counter to 0, or to TOP when counting down.
- R6: A one-cycle high on `slave_upd_i` has the same effect as a TRIG write.
- R7: A write to DIV or TOP does not change the current period. The new value is used only after the next update.
- R8: While CTRL bit 0 is 0, ticks are ignored: `cnt_o` holds and no natural update occurs.
- R9: The repetition counter reloads REPS and counts down on each counter event. An update fires only on an event that finds it at 0.
- R10: After reset, `update_o` and `cnt_o` are 0. `update_o` is a one-cycle pulse per update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable tick from the selected clock source |
| slave_upd_i | input | 1 | External forced-update request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| update_o | output | 1 | Update event pulse |
| cnt_o | output | 16 | Current main counter value |

## Verification
The assertions assume that the shadow divider and shadow limit change only at an update. They also assume that a forced update and a register write never share a cycle, which the single write port guarantees for TRIG. The bench keeps to these assumptions: each configuration is written first and a forced update follows, so every measured period starts from a clean restart. Centre-aligned runs use a reload limit of at least 1, the range in which the centre spacing rule holds.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2
  } cnt_mode_e;

  localparam int unsigned ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_REPS = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd4;
endpackage

// File: rtl/tbg_regs.sv
module tbg_regs
  import tbg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              upd_i,
  output logic              sw_req_o,
  output logic              en_o,
  output cnt_mode_e         mode_o,
  output logic [W-1:0]      div_sh_o,
  output logic [W-1:0]      top_sh_o,
  output logic [W-1:0]      top_pre_o,
  output logic [W-1:0]      reps_o
);
  logic [3:0]   ctrl_q;
  logic [W-1:0] div_pre_q, top_pre_q, reps_q, div_sh_q, top_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      div_pre_q <= '0;
      top_pre_q <= '0;
      reps_q    <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL:  ctrl_q    <= wr_data_i[3:0];
        A_DIV:   div_pre_q <= wr_data_i;
        A_TOP:   top_pre_q <= wr_data_i;
        A_REPS:  reps_q    <= wr_data_i;
        default: ;
      endcase
    end
  end

  // shadows follow the preload only on an update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_sh_q <= '0;
      top_sh_q <= '0;
    end else if (upd_i) begin
      div_sh_q <= div_pre_q;
      top_sh_q <= top_pre_q;
    end
  end

  assign sw_req_o  = wr_en_i && (wr_addr_i == A_TRIG) && wr_data_i[0];
  assign en_o      = ctrl_q[0];
  assign mode_o    = (ctrl_q[3:2] != 2'b00) ? MODE_CENTER :
                     (ctrl_q[1] ? MODE_DOWN : MODE_UP);
  assign div_sh_o  = div_sh_q;
  assign top_sh_o  = top_sh_q;
  assign top_pre_o = top_pre_q;
  assign reps_o    = reps_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(div_sh_q) && $stable(top_sh_q))); // R7
endmodule

// File: rtl/tbg_prescaler.sv
module tbg_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  output logic         step_o
);
  logic [W-1:0] pc_q;
  logic         wrap;

  assign wrap   = (pc_q >= div_i);
  assign step_o = en_i && tick_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pc_q <= '0;
    else if (clr_i)          pc_q <= '0;
    else if (en_i && tick_i) pc_q <= wrap ? '0 : pc_q + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= div_i); // R1
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pc_q)); // R8
endmodule

// File: rtl/tbg_counter.sv
module tbg_counter
  import tbg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] top_sh_i,
  input  logic [W-1:0] top_next_i,
  output logic [W-1:0] cnt_o,
  output logic         evt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic         at_end;

  always_comb begin
    unique case (mode_i)
      MODE_DOWN:   at_end = (cnt_q == '0);
      MODE_CENTER: at_end = (top_sh_i == '0) ||
                            (up_q ? (cnt_q >= top_sh_i - ONE) : (cnt_q <= ONE));
      default:     at_end = (cnt_q >= top_sh_i);
    endcase
  end
  assign evt_o = step_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= (mode_i == MODE_DOWN) ? top_next_i : '0;
      up_q  <= 1'b1;
    end else if (step_i) begin
      unique case (mode_i)
        MODE_DOWN: cnt_q <= at_end ? top_next_i : cnt_q - ONE;
        MODE_CENTER: begin
          if (top_sh_i == '0) cnt_q <= '0;
          else if (up_q) begin
            if (at_end) begin
              cnt_q <= top_next_i;
              up_q  <= 1'b0;
            end else cnt_q <= cnt_q + ONE;
          end else begin
            if (at_end) begin
              cnt_q <= '0;
              up_q  <= 1'b1;
            end else cnt_q <= cnt_q - ONE;
          end
        end
        default: cnt_q <= at_end ? '0 : cnt_q + ONE;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= top_sh_i); // R2
  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP && evt_o && !clr_i) |=> (cnt_q == '0)); // R2
  AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DOWN && step_i && !clr_i && cnt_q == '0)
      |=> (cnt_q == $past(top_next_i))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/tbg_repeat.sv
module tbg_repeat #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         clr_i,
  input  logic [W-1:0] reps_i,
  output logic         hit_o,
  output logic         upd_o
);
  logic [W-1:0] rep_q;
  logic         upd_q;

  assign hit_o = evt_i && (rep_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= clr_i || hit_o;
      if (clr_i || hit_o) rep_q <= reps_i;
      else if (evt_i)     rep_q <= rep_q - 1'b1;
    end
  end

  assign upd_o = upd_q;

  AST_FORCE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> upd_o); // R5
  AST_REP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !clr_i) |=> $stable(rep_q)); // R9
  AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !clr_i && rep_q != '0) |=> !upd_o); // R9
endmodule

// File: rtl/timebase_gen.sv
module timebase_gen
  import tbg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              slave_upd_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic              update_o,
  output logic [W-1:0]      cnt_o
);
  logic         sw_req, force_upd, upd_now, en, step, evt, hit;
  cnt_mode_e    mode;
  logic [W-1:0] div_sh, top_sh, top_pre, reps, top_next;

  assign force_upd = sw_req || slave_upd_i;
  assign upd_now   = force_upd || hit;
  assign top_next  = upd_now ? top_pre : top_sh;

  tbg_regs #(.W(W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .upd_i(upd_now), .sw_req_o(sw_req), .en_o(en), .mode_o(mode),
    .div_sh_o(div_sh), .top_sh_o(top_sh), .top_pre_o(top_pre), .reps_o(reps)
  );

  tbg_prescaler #(.W(W)) i_div (
    .clk_i, .rst_ni, .en_i(en), .tick_i, .clr_i(force_upd),
    .div_i(div_sh), .step_o(step)
  );

  tbg_counter #(.W(W)) i_cnt (
    .clk_i, .rst_ni, .step_i(step), .clr_i(force_upd), .mode_i(mode),
    .top_sh_i(top_sh), .top_next_i(top_next), .cnt_o(cnt_o), .evt_o(evt)
  );

  tbg_repeat #(.W(W)) i_rep (
    .clk_i, .rst_ni, .evt_i(evt), .clr_i(force_upd), .reps_i(reps),
    .hit_o(hit), .upd_o(update_o)
  );

  AST_FORCE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_upd && mode == MODE_UP) |=> (cnt_o == '0)); // R5
  AST_SLAVE_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_upd_i |=> update_o); // R6
endmodule

// File: tb/test_timebase_gen.sv
`timescale 1ns/1ps
module test_timebase_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        slave_upd_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        update_o;
  logic [15:0] cnt_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  timebase_gen i_timebase_gen (
    .clk_i, .rst_ni, .tick_i, .slave_upd_i, .wr_en_i, .wr_addr_i,
    .wr_data_i, .update_o, .cnt_o
  );

  // {ctrl[3:0], div, top, reps}; ctrl 1=up, 3=down, 5=centre
  localparam logic [51:0] VEC [8] = '{
    {4'h1, 16'd0, 16'd3, 16'd0},
    {4'h1, 16'd1, 16'd3, 16'd0},
    {4'h3, 16'd0, 16'd4, 16'd1},
    {4'h1, 16'd2, 16'd2, 16'd2},
    {4'h5, 16'd1, 16'd3, 16'd0},
    {4'h5, 16'd0, 16'd5, 16'd1},
    {4'h1, 16'd0, 16'd0, 16'd0},
    {4'h3, 16'd3, 16'd1, 16'd3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic setup(input logic [3:0] c, input int dv, input int tp, input int rp);
    wr(3'd0, 16'(c)); wr(3'd1, 16'(dv)); wr(3'd2, 16'(tp)); wr(3'd3, 16'(rp));
  endtask

  // TRIG write; returns at the first negedge after it, where the pulse must be high
  task automatic force_sw();
    wr(3'd4, 16'd1);
    chk(update_o == 1'b1, "R5 trig pulse", int'(update_o), 1);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!update_o && n < 140000);
  endtask

  initial begin
    #(1900000ns);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, v;
    repeat (3) @(negedge clk_i);
    chk(update_o == 1'b0, "R10 reset update", int'(update_o), 0);
    chk(cnt_o == 16'd0, "R10 reset count", int'(cnt_o), 0);
    rst_ni = 1'b1;
    tick_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(cnt_o == 16'd0 && !update_o, "R8 disabled after reset", int'(cnt_o), 0);

    // vector table: period between forced and first natural update
    for (int i = 0; i < 8; i++) begin
      int dv, tp, rp, e;
      logic [3:0] c;
      c  = VEC[i][51:48];
      dv = int'(VEC[i][47:32]);
      tp = int'(VEC[i][31:16]);
      rp = int'(VEC[i][15:0]);
      e  = (c[3:2] != 2'b00) ? (dv + 1) * tp * (rp + 1) : (dv + 1) * (tp + 1) * (rp + 1);
      setup(c, dv, tp, rp);
      force_sw();
      measure(n);
      chk(n == e, (c[3:2] != 2'b00) ? "R4 centre period" : "R1 R9 period", n, e);
    end

    // R1 long case
    setup(4'h1, 1, 65535, 0);
    force_sw();
    measure(n);
    chk(n == 131072, "R1 div1 top65535", n, 131072);

    // R2 up sequence and R10 single pulse
    setup(4'h1, 0, 3, 0);
    force_sw();
    chk(cnt_o == 16'd0, "R5 up restart", int'(cnt_o), 0);
    @(negedge clk_i);
    chk(update_o == 1'b0, "R10 one-cycle pulse", int'(update_o), 0);
    @(negedge clk_i);
    chk(cnt_o == 16'd2, "R2 up step", int'(cnt_o), 2);
    repeat (2) @(negedge clk_i);
    chk(cnt_o == 16'd0 && update_o, "R2 up wrap", int'(cnt_o), 0);

    // R3 down sequence
    setup(4'h3, 0, 4, 0);
    force_sw();
    chk(cnt_o == 16'd4, "R3 R5 down restart", int'(cnt_o), 4);
    @(negedge clk_i);
    chk(cnt_o == 16'd3, "R3 down step", int'(cnt_o), 3);
    repeat (3) @(negedge clk_i);
    chk(cnt_o == 16'd0 && !update_o, "R3 down zero", int'(cnt_o), 0);
    @(negedge clk_i);
    chk(cnt_o == 16'd4 && update_o, "R3 down reload", int'(cnt_o), 4);

    // R4 centre turning points
    setup(4'h5, 0, 3, 0);
    force_sw();
    repeat (3) @(negedge clk_i);
    chk(cnt_o == 16'd3 && update_o, "R4 centre top", int'(cnt_o), 3);
    repeat (3) @(negedge clk_i);
    chk(cnt_o == 16'd0 && update_o, "R4 centre bottom", int'(cnt_o), 0);

    // R7 shadowed limit
    setup(4'h1, 0, 3, 0);
    force_sw();
    wr(3'd2, 16'd7);
    measure(n);
    chk(n == 3, "R7 old limit kept", n, 3);
    measure(n);
    chk(n == 8, "R7 new limit after update", n, 8);

    // R8 enable cleared
    setup(4'h1, 0, 9, 0);
    force_sw();
    @(negedge clk_i);
    wr(3'd0, 16'd0);
    v = int'(cnt_o);
    n = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (update_o) n++;
    end
    chk(n == 0, "R8 no update while off", n, 0);
    chk(int'(cnt_o) == v, "R8 count holds", int'(cnt_o), v);

    // R6 slave request
    wr(3'd0, 16'd1);
    repeat (4) @(negedge clk_i);
    slave_upd_i = 1'b1;
    @(negedge clk_i);
    slave_upd_i = 1'b0;
    chk(update_o == 1'b1, "R6 slave pulse", int'(update_o), 1);
    chk(cnt_o == 16'd0, "R6 slave restart", int'(cnt_o), 0);
    measure(n);
    chk(n == 10, "R6 period after slave", n, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule